// File: doc/BRIEF.md
# Address Translation Fault Reporter

This block sits between a processor's memory access port (load, store or instruction fetch) and a small table of translation entries. When translation is both available in the configuration and switched on by the running software, the virtual page number of each request is matched against the table. A matching entry gives the physical page and the access permissions. A request that matches no entry, or that matches an entry which forbids that kind of access, raises a memory-management fault. The faulting address and a status code describing the fault are captured into registered outputs. When translation is unavailable or switched off, the page part of the address passes through unchanged.

Faults are reported one cycle after the offending request. A reported fault stays pending until the exception handler acknowledges it. A second translation fault that arrives while one is still pending cannot be handled safely, so it is reported on a separate fatal strobe and leaves the captured address and status untouched. The table is written through a simple entry-write port. Each entry covers a power-of-two run of pages.

Top module: `xlat_fault_unit`

## Requirements
- R1: Translation is active only when `cfg_mmu_present` and `vm_enable` are both 1 and it is not the case that `cfg_full_cfg` is 1 while `cfg_ext_mmu` is 0. In every other configuration no request faults and `xlat_ok` equals `req_valid`.
- R2: While translation is inactive, `phys_addr` carries the page number of `req_vaddr` in its upper bits, and its lower `PAGE_BITS` bits are zero (default page size 4 KiB, `PAGE_BITS`=12).
- R3: An entry matches when it is valid and the request's page number equals the entry's virtual base page in every bit except the lowest `span` bits. On a permitted match, `phys_addr` = (physical base page + request page − virtual base page) shifted left by `PAGE_BITS`, and `xlat_ok` is 1 in the same cycle.
- R4: When several entries match, the lowest-numbered entry alone decides the physical page and the permission outcome.
- R5: While translation is active, a valid request that matches no entry gives `mmu_fault` = 1 in the next cycle. The status code in `fault_esr[4:0]` is 18 for a load or store and 19 for a fetch. The access kind is encoded on `req_kind` as 0 for load, 1 for store and 2 for fetch; 3 behaves as a load.
- R6: A match whose permission bit for the access is clear is a protection fault, reported like R5 but with code 16 for data and 17 for fetch. The permission bits in `tbl_wr_perm` are bit 0 for read (loads), bit 1 for write (stores) and bit 2 for execute (fetches).
- R7: `fault_esr` bit 10 is 1 exactly when the faulting access is a store, so a fetch never sets it. All other bits above bit 4 are zero.
- R8: On a reported fault, `fault_ear` receives the full faulting `req_vaddr`. `fault_ear` and `fault_esr` hold their value until the next reported fault.
- R9: `mmu_fault` is a single-cycle strobe. After it, the fault stays pending until `exc_ack` is sampled 1.
- R10: A fault request while a fault is pending and `exc_ack` is 0 gives `fault_fatal` = 1 for one cycle, gives no `mmu_fault`, and leaves `fault_ear` and `fault_esr` unchanged. When `exc_ack` is 1 in the same cycle as the fault request, the fault is reported normally.
- R11: After reset, `mmu_fault`, `fault_fatal`, `fault_ear` and `fault_esr` are zero, and all table entries are invalid.
- R12: A request with `req_valid` = 0 never raises a fault and gives `xlat_ok` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mmu_present | input | 1 | Translation hardware is built in |
| cfg_full_cfg | input | 1 | Extended configuration word is in force |
| cfg_ext_mmu | input | 1 | Extended configuration confirms translation use |
| vm_enable | input | 1 | Software has switched translation on |
| req_valid | input | 1 | An access request is present |
| req_kind | input | 2 | 0 load, 1 store, 2 fetch |
| req_vaddr | input | AW | Virtual address of the request |
| exc_ack | input | 1 | Exception handler acknowledges the pending fault |
| tbl_wr_en | input | 1 | Write one table entry |
| tbl_wr_idx | input | IDX_W | Entry to write |
| tbl_wr_valid | input | 1 | Valid bit for the written entry |
| tbl_wr_vbase | input | AW-PAGE_BITS | Virtual base page |
| tbl_wr_pbase | input | AW-PAGE_BITS | Physical base page |
| tbl_wr_span | input | SPAN_W | Log2 of the number of pages covered |
| tbl_wr_perm | input | 3 | Permission bits: read, write, execute |
| phys_addr | output | AW | Page-aligned physical address |
| xlat_ok | output | 1 | Request is valid and does not fault |
| mmu_fault | output | 1 | Registered fault strobe |
| fault_ear | output | AW | Captured faulting address |
| fault_esr | output | ESR_W | Captured fault status |
| fault_fatal | output | 1 | Registered nested-fault strobe |

## Verification
A corrupted table entry or a wrong match priority shows at once as a wrong `phys_addr`, or a wrong `xlat_ok`, in the same cycle as the request. A bad status or address capture shows on `fault_esr` and `fault_ear` one cycle later and remains visible until the next fault. A pending flag that is stuck set or stuck clear only shows on the next faulting request, which then raises the wrong one of `mmu_fault` and `fault_fatal`. The bench therefore sweeps every configuration, access kind and page class against a table with overlapping entries, and then runs back-to-back faults with and without acknowledge.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2
    } acc_kind_e;

    localparam int PERM_RD = 0;
    localparam int PERM_WR = 1;
    localparam int PERM_EX = 2;

    localparam int STORE_BIT = 10;

    // Status code layout: {1'b1, 2'b00, miss, fetch}
    localparam logic [2:0] CODE_TOP = 3'b100;

endpackage

// File: rtl/xlat_table.sv
module xlat_table #(
    parameter int VPN_W   = 20,
    parameter int ENTRIES = 4,
    parameter int SPAN_W  = 2,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_valid,
    input  logic [VPN_W-1:0] wr_vbase,
    input  logic [VPN_W-1:0] wr_pbase,
    input  logic [SPAN_W-1:0] wr_span,
    input  logic [2:0]       wr_perm,
    input  logic [VPN_W-1:0] lk_vpn,
    input  logic [2:0]       lk_need,
    output logic             lk_hit,
    output logic             lk_perm_ok,
    output logic [VPN_W-1:0] lk_ppn
);

    logic [ENTRIES-1:0] val_d, val_q;
    logic [VPN_W-1:0]   vb_d [ENTRIES];
    logic [VPN_W-1:0]   vb_q [ENTRIES];
    logic [VPN_W-1:0]   pb_d [ENTRIES];
    logic [VPN_W-1:0]   pb_q [ENTRIES];
    logic [SPAN_W-1:0]  sp_d [ENTRIES];
    logic [SPAN_W-1:0]  sp_q [ENTRIES];
    logic [2:0]         pm_d [ENTRIES];
    logic [2:0]         pm_q [ENTRIES];

    always_comb begin
        val_d = val_q;
        vb_d  = vb_q;
        pb_d  = pb_q;
        sp_d  = sp_q;
        pm_d  = pm_q;
        if (wr_en) begin
            val_d[wr_idx] = wr_valid;
            vb_d[wr_idx]  = wr_vbase;
            pb_d[wr_idx]  = wr_pbase;
            sp_d[wr_idx]  = wr_span;
            pm_d[wr_idx]  = wr_perm;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val_q <= '0;
            for (int i = 0; i < ENTRIES; i++) begin
                vb_q[i] <= '0;
                pb_q[i] <= '0;
                sp_q[i] <= '0;
                pm_q[i] <= '0;
            end
        end else begin
            val_q <= val_d;
            vb_q  <= vb_d;
            pb_q  <= pb_d;
            sp_q  <= sp_d;
            pm_q  <= pm_d;
        end
    end

    // Per-entry match: compare every page bit above the entry's span
    logic [ENTRIES-1:0] match;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        logic [VPN_W-1:0] above_span;
        assign above_span = (lk_vpn ^ vb_q[g]) >> sp_q[g];
        assign match[g]   = val_q[g] && (above_span == '0);
    end

    // Lowest index wins
    logic [IDX_W-1:0] sel;

    always_comb begin
        sel = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) sel = IDX_W'(i);
        end
    end

    assign lk_hit     = |match;
    assign lk_perm_ok = |(pm_q[sel] & lk_need);
    assign lk_ppn     = pb_q[sel] + (lk_vpn - vb_q[sel]);

endmodule

// File: rtl/xlat_esr_enc.sv
module xlat_esr_enc
    import xlat_pkg::*;
#(
    parameter int ESR_W = 32
) (
    input  logic             is_miss,
    input  logic [1:0]       kind,
    output logic [ESR_W-1:0] esr
);

    logic is_fetch;
    logic is_store;

    assign is_fetch = (kind == ACC_FETCH);
    assign is_store = (kind == ACC_STORE);

    always_comb begin
        esr            = '0;
        esr[4:0]       = {CODE_TOP, is_miss, is_fetch};
        esr[STORE_BIT] = is_store;
    end

endmodule

// File: rtl/xlat_fault_unit.sv
module xlat_fault_unit
    import xlat_pkg::*;
#(
    parameter int AW        = 32,
    parameter int PAGE_BITS = 12,
    parameter int ENTRIES   = 4,
    parameter int SPAN_W    = 2,
    parameter int ESR_W     = 32,
    localparam int VPN_W    = AW - PAGE_BITS,
    localparam int IDX_W    = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_mmu_present,
    input  logic              cfg_full_cfg,
    input  logic              cfg_ext_mmu,
    input  logic              vm_enable,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [AW-1:0]     req_vaddr,
    input  logic              exc_ack,
    input  logic              tbl_wr_en,
    input  logic [IDX_W-1:0]  tbl_wr_idx,
    input  logic              tbl_wr_valid,
    input  logic [VPN_W-1:0]  tbl_wr_vbase,
    input  logic [VPN_W-1:0]  tbl_wr_pbase,
    input  logic [SPAN_W-1:0] tbl_wr_span,
    input  logic [2:0]        tbl_wr_perm,
    output logic [AW-1:0]     phys_addr,
    output logic              xlat_ok,
    output logic              mmu_fault,
    output logic [AW-1:0]     fault_ear,
    output logic [ESR_W-1:0]  fault_esr,
    output logic              fault_fatal
);

    typedef struct packed {
        logic             fault;
        logic             fatal;
        logic             pending;
        logic [AW-1:0]    ear;
        logic [ESR_W-1:0] esr;
    } st_t;

    st_t st_d, st_q;

    logic             xlat_on;
    logic [VPN_W-1:0] vpn;
    logic [2:0]       need;
    logic             hit;
    logic             perm_ok;
    logic [VPN_W-1:0] ppn;
    logic             miss;
    logic             prot;
    logic             flt;
    logic [ESR_W-1:0] esr_new;
    logic             pend_eff;
    logic             pending_q;

    assign xlat_on = cfg_mmu_present && vm_enable && !(cfg_full_cfg && !cfg_ext_mmu);
    assign vpn     = req_vaddr[AW-1:PAGE_BITS];

    always_comb begin
        need = '0;
        unique case (req_kind)
            ACC_FETCH: need[PERM_EX] = 1'b1;
            ACC_STORE: need[PERM_WR] = 1'b1;
            default:   need[PERM_RD] = 1'b1;
        endcase
    end

    xlat_table #(
        .VPN_W   (VPN_W),
        .ENTRIES (ENTRIES),
        .SPAN_W  (SPAN_W)
    ) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (tbl_wr_en),
        .wr_idx     (tbl_wr_idx),
        .wr_valid   (tbl_wr_valid),
        .wr_vbase   (tbl_wr_vbase),
        .wr_pbase   (tbl_wr_pbase),
        .wr_span    (tbl_wr_span),
        .wr_perm    (tbl_wr_perm),
        .lk_vpn     (vpn),
        .lk_need    (need),
        .lk_hit     (hit),
        .lk_perm_ok (perm_ok),
        .lk_ppn     (ppn)
    );

    assign miss = xlat_on && !hit;
    assign prot = xlat_on && hit && !perm_ok;
    assign flt  = req_valid && (miss || prot);

    xlat_esr_enc #(
        .ESR_W (ESR_W)
    ) u_enc (
        .is_miss (miss),
        .kind    (req_kind),
        .esr     (esr_new)
    );

    assign phys_addr = {(xlat_on ? ppn : vpn), {PAGE_BITS{1'b0}}};
    assign xlat_ok   = req_valid && !(miss || prot);

    assign pend_eff = st_q.pending && !exc_ack;

    always_comb begin
        st_d         = st_q;
        st_d.fault   = 1'b0;
        st_d.fatal   = 1'b0;
        st_d.pending = pend_eff;
        if (flt) begin
            if (pend_eff) begin
                st_d.fatal = 1'b1;
            end else begin
                st_d.fault   = 1'b1;
                st_d.pending = 1'b1;
                st_d.ear     = req_vaddr;
                st_d.esr     = esr_new;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pending_q   = st_q.pending;
    assign mmu_fault   = st_q.fault;
    assign fault_fatal = st_q.fatal;
    assign fault_ear   = st_q.ear;
    assign fault_esr   = st_q.esr;

endmodule

// File: rtl/xlat_fault_chk.sv
module xlat_fault_chk #(
    parameter int AW        = 32,
    parameter int PAGE_BITS = 12,
    parameter int ESR_W     = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [1:0]       req_kind,
    input logic [AW-1:0]    req_vaddr,
    input logic             cfg_mmu_present,
    input logic             vm_enable,
    input logic [AW-1:0]    phys_addr,
    input logic             mmu_fault,
    input logic             fault_fatal,
    input logic [AW-1:0]    fault_ear,
    input logic [ESR_W-1:0] fault_esr,
    input logic             pending
);

    // R2
    passthrough_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_mmu_present && vm_enable) |->
            phys_addr[AW-1:PAGE_BITS] == req_vaddr[AW-1:PAGE_BITS]);

    // R2
    page_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phys_addr[PAGE_BITS-1:0] == '0);

    // R5
    esr_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mmu_fault |-> fault_esr[4:2] == 3'b100);

    // R7
    fetch_no_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mmu_fault && $past(req_kind) == 2'd2) |-> !fault_esr[10]);

    // R8
    ear_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mmu_fault |-> fault_ear == $past(req_vaddr));

    // R8
    ear_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mmu_fault |-> ($stable(fault_ear) && $stable(fault_esr)));

    // R9
    fault_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mmu_fault |-> pending);

    // R10
    fatal_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_fatal |-> $past(pending));

    // R10
    fatal_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(fault_fatal && mmu_fault));

    // R12
    idle_no_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(req_valid) |-> !(mmu_fault || fault_fatal));

endmodule

bind xlat_fault_unit xlat_fault_chk #(
    .AW        (AW),
    .PAGE_BITS (PAGE_BITS),
    .ESR_W     (ESR_W)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .req_valid       (req_valid),
    .req_kind        (req_kind),
    .req_vaddr       (req_vaddr),
    .cfg_mmu_present (cfg_mmu_present),
    .vm_enable       (vm_enable),
    .phys_addr       (phys_addr),
    .mmu_fault       (mmu_fault),
    .fault_fatal     (fault_fatal),
    .fault_ear       (fault_ear),
    .fault_esr       (fault_esr),
    .pending         (pending_q)
);

// File: tb/xlat_fault_unit_bench.sv
`timescale 1ns/1ps
module xlat_fault_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_mmu_present = 0, cfg_full_cfg = 0, cfg_ext_mmu = 0, vm_enable = 0;
    logic        req_valid = 0;
    logic [1:0]  req_kind = 0;
    logic [31:0] req_vaddr = 0;
    logic        exc_ack = 0;
    logic        tbl_wr_en = 0;
    logic [1:0]  tbl_wr_idx = 0;
    logic        tbl_wr_valid = 0;
    logic [19:0] tbl_wr_vbase = 0, tbl_wr_pbase = 0;
    logic [1:0]  tbl_wr_span = 0;
    logic [2:0]  tbl_wr_perm = 0;
    logic [31:0] phys_addr;
    logic        xlat_ok, mmu_fault, fault_fatal;
    logic [31:0] fault_ear, fault_esr;

    always #4 clk = ~clk;

    xlat_fault_unit u_xlat_fault_unit (
        .clk(clk), .rst_n(rst_n),
        .cfg_mmu_present(cfg_mmu_present), .cfg_full_cfg(cfg_full_cfg),
        .cfg_ext_mmu(cfg_ext_mmu), .vm_enable(vm_enable),
        .req_valid(req_valid), .req_kind(req_kind), .req_vaddr(req_vaddr),
        .exc_ack(exc_ack),
        .tbl_wr_en(tbl_wr_en), .tbl_wr_idx(tbl_wr_idx), .tbl_wr_valid(tbl_wr_valid),
        .tbl_wr_vbase(tbl_wr_vbase), .tbl_wr_pbase(tbl_wr_pbase),
        .tbl_wr_span(tbl_wr_span), .tbl_wr_perm(tbl_wr_perm),
        .phys_addr(phys_addr), .xlat_ok(xlat_ok), .mmu_fault(mmu_fault),
        .fault_ear(fault_ear), .fault_esr(fault_esr), .fault_fatal(fault_fatal)
    );

    int n_chk = 0;
    int n_bad = 0;

    // bench copy of the table contents
    bit [19:0] m_vb [4];
    bit [19:0] m_pb [4];
    int        m_sp [4];
    bit [2:0]  m_pm [4];
    bit        m_v  [4];
    bit [31:0] exp_ear = 0, exp_esr = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input int idx, input bit v, input int vb, input int pb,
                      input int sp, input int pm);
        @(negedge clk);
        tbl_wr_en = 1; tbl_wr_idx = idx[1:0]; tbl_wr_valid = v;
        tbl_wr_vbase = vb[19:0]; tbl_wr_pbase = pb[19:0];
        tbl_wr_span = sp[1:0]; tbl_wr_perm = pm[2:0];
        m_v[idx] = v; m_vb[idx] = vb[19:0]; m_pb[idx] = pb[19:0];
        m_sp[idx] = sp; m_pm[idx] = pm[2:0];
        @(negedge clk);
        tbl_wr_en = 0;
    endtask

    // expected outcome computed from the requirements
    function automatic void model(input bit [31:0] va, input bit [1:0] k,
                                  output bit ok, output bit f, output bit [31:0] ph,
                                  output bit [4:0] code, output bit is_miss);
        bit en; bit [19:0] vpn; int hit_i; bit [2:0] need;
        en = cfg_mmu_present && vm_enable && !(cfg_full_cfg && !cfg_ext_mmu);
        vpn = va[31:12];
        ok = 1; f = 0; code = 0; is_miss = 0;
        ph = {vpn, 12'h000};
        if (en) begin
            hit_i = -1;
            for (int i = 3; i >= 0; i--)
                if (m_v[i] && ((vpn ^ m_vb[i]) >> m_sp[i]) == 0) hit_i = i;
            need = (k == 2) ? 3'b100 : (k == 1) ? 3'b010 : 3'b001;
            if (hit_i < 0) begin
                f = 1; ok = 0; is_miss = 1; code = (k == 2) ? 5'd19 : 5'd18;
            end else if ((m_pm[hit_i] & need) == 0) begin
                f = 1; ok = 0; code = (k == 2) ? 5'd17 : 5'd16;
            end else begin
                ph = {20'(m_pb[hit_i] + vpn - m_vb[hit_i]), 12'h000};
            end
        end
    endfunction

    task automatic req(input bit [31:0] va, input bit [1:0] k, input bit ack_after);
        bit ok, f, mi; bit [31:0] ph; bit [4:0] code; bit en;
        string ptag, ftag;
        @(negedge clk);
        req_valid = 1; req_kind = k; req_vaddr = va;
        model(va, k, ok, f, ph, code, mi);
        en = cfg_mmu_present && vm_enable && !(cfg_full_cfg && !cfg_ext_mmu);
        #1;
        chk("R1 xlat_ok", {31'd0, xlat_ok}, {31'd0, ok});
        if (ok) begin
            ptag = !en ? "R2 passthrough" :
                   (va[31:12] >= 20'h20 && va[31:12] <= 20'h23) ? "R4 priority phys" : "R3 phys";
            chk(ptag, phys_addr, ph);
        end
        @(negedge clk);
        req_valid = 0;
        ftag = !f ? "R9 no fault" : mi ? "R5 miss fault" : "R6 protection fault";
        chk(ftag, {31'd0, mmu_fault}, {31'd0, f});
        chk("R10 fatal idle", {31'd0, fault_fatal}, 32'd0);
        if (f) begin
            exp_ear = va;
            exp_esr = {21'd0, (k == 2'd1), 5'd0, code};
        end
        chk("R7 esr", fault_esr, exp_esr);
        chk("R8 ear", fault_ear, exp_ear);
        if (ack_after && f) begin
            exc_ack = 1;
            @(negedge clk);
            exc_ack = 0;
        end
    endtask

    initial begin
        #(8 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        bit [2:0] list_k;
        int vpns [10] = '{'h10, 'h11, 'h20, 'h22, 'h23, 'h24, 'h40, 'h41, 'h42, 'h07};
        for (int i = 0; i < 4; i++) begin
            m_v[i] = 0; m_vb[i] = 0; m_pb[i] = 0; m_sp[i] = 0; m_pm[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R11 reset state
        chk("R11 fault", {31'd0, mmu_fault}, 32'd0);
        chk("R11 fatal", {31'd0, fault_fatal}, 32'd0);
        chk("R11 ear", fault_ear, 32'd0);
        chk("R11 esr", fault_esr, 32'd0);
        // R11 entries invalid: any active lookup misses
        cfg_mmu_present = 1; vm_enable = 1;
        req(32'h0001_0abc, 2'd0, 1);

        // overlapping entries 1 and 2 exercise R4
        wr(0, 1, 'h10, 'h80, 0, 3'b001);
        wr(1, 1, 'h20, 'h1A3, 2, 3'b111);
        wr(2, 1, 'h20, 'h300, 0, 3'b011);
        wr(3, 1, 'h40, 'h05, 1, 3'b100);

        for (int c = 0; c < 16; c++) begin
            cfg_mmu_present = c[0]; vm_enable = c[1];
            cfg_full_cfg = c[2]; cfg_ext_mmu = c[3];
            for (int k = 0; k < 4; k++)
                for (int a = 0; a < 10; a++)
                    req({vpns[a][19:0], 12'((a * 373 + k * 91 + c) % 4096)}, k[1:0], 1);
        end

        // R10 nested fault without acknowledge
        cfg_mmu_present = 1; vm_enable = 1; cfg_full_cfg = 0; cfg_ext_mmu = 0;
        req(32'h0000_7123, 2'd0, 0);
        @(negedge clk);
        req_valid = 1; req_kind = 2'd1; req_vaddr = 32'h0001_0456;
        @(negedge clk);
        req_valid = 0;
        chk("R10 nested fatal", {31'd0, fault_fatal}, 32'd1);
        chk("R10 nested no strobe", {31'd0, mmu_fault}, 32'd0);
        chk("R10 ear kept", fault_ear, 32'h0000_7123);
        chk("R10 esr kept", fault_esr, 32'd18);
        // acknowledge in the same cycle as a new fault: reported normally
        @(negedge clk);
        req_valid = 1; req_kind = 2'd2; req_vaddr = 32'h0004_2fff; exc_ack = 1;
        @(negedge clk);
        req_valid = 0; exc_ack = 0;
        chk("R10 ack same cycle fault", {31'd0, mmu_fault}, 32'd1);
        chk("R10 ack same cycle fatal", {31'd0, fault_fatal}, 32'd0);
        chk("R10 ack same cycle esr", fault_esr, 32'd19);
        chk("R10 ack same cycle ear", fault_ear, 32'h0004_2fff);
        exc_ack = 1;
        @(negedge clk);
        exc_ack = 0;

        // R12 invalid request with a missing page
        @(negedge clk);
        req_valid = 0; req_kind = 2'd1; req_vaddr = 32'h0009_9000;
        #1;
        chk("R12 xlat_ok low", {31'd0, xlat_ok}, 32'd0);
        @(negedge clk);
        chk("R12 no fault", {31'd0, mmu_fault}, 32'd0);
        chk("R12 ear kept", fault_ear, 32'h0004_2fff);

        // R9 pending cleared: a fresh fault strobes normally again
        req(32'h0009_9010, 2'd1, 1);
        list_k = 0;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule